// File: doc/BRIEF.md
# Receive Message Queue with Selectable Capacity

This block buffers message words delivered by a CAN-style receive engine until host logic drains them. A 32-bit control word, written with per-byte enables, turns the queue on, picks its usable capacity from eight codes (among them the non-power-of-two value 48), and chooses how the interrupt request behaves. Incoming words arrive through a single-cycle push strobe. The oldest stored word is always presented on the pop data output, and a pop strobe removes it.

The block reports full, empty, the current fill level and a sticky overflow flag. Its interrupt output is a one-cycle pulse. In threshold mode the pulse fires when the level climbs to a programmed eighth-fraction of the capacity. In per-message mode it fires for every stored word. Changing the capacity, or switching the queue off, empties the queue at once.

Top module: `rxq_fifo`

## Requirements
- R1: After reset the control word reads 0, level is 0, overflow and irq are 0, and full and empty are both 1.
- R2: Control word layout: bit 0 on, bit 1 interrupt enable, bits 10:8 capacity code, bit 12 per-message mode, bits 15:13 threshold code. Every other bit reads 0. A write changes bits 7:0 only when cfg_be[0] is set and bits 15:8 only when cfg_be[1] is set. A write with cfg_be = 0 changes nothing.
- R3: Capacity codes 0..7 give 0, 4, 8, 16, 32, 48, 64, 128 words. With the queue on, full rises exactly when the level equals that capacity.
- R4: While bit 0 is 0 no pushed word is stored and the level stays 0. Clearing bit 0 while it was set empties the queue.
- R5: Words leave in the order they arrived. pop_data shows the oldest stored word, and each accepted push or pop changes level by one in the cycle after the strobe.
- R6: A push while full is dropped (level unchanged) and sets overflow. Overflow stays set until the queue is emptied by a reconfiguration (R4, R8).
- R7: A pop while empty is ignored: level stays 0 and empty stays 1.
- R8: A write that changes the capacity code sets level to 0 and clears overflow. Words pushed afterwards are read back starting from the first of them.
- R9: Capacity code 0 reports full and empty together, stores nothing, and a push while on sets overflow.
- R10: In threshold mode (bit 12 = 0), irq pulses once in the cycle after the push that raises the level to exactly ceil(capacity*(n+1)/8), where n is the threshold code. It does not repeat while the level stays at or above that count. It fires again after the level drops below it and climbs back.
- R11: In per-message mode (bit 12 = 1), irq pulses in the cycle after every stored word.
- R12: With bit 1 = 0, irq stays 0 in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_be | input | 4 | Byte enables for the control write |
| cfg_wdata | input | 32 | Control write data |
| cfg_rdata | output | 32 | Control word readback |
| push_valid | input | 1 | Store one word this cycle |
| push_data | input | DATA_W | Word to store |
| pop_req | input | 1 | Remove the oldest word this cycle |
| pop_data | output | DATA_W | Oldest stored word |
| full | output | 1 | Level equals capacity |
| empty | output | 1 | Level is zero |
| level | output | $clog2(MAX_DEPTH+1) | Number of stored words |
| overflow | output | 1 | Sticky dropped-push flag |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The hardest situation to reach is a threshold crossing at the far end of a large, non-power-of-two capacity. Examples are the 42nd word of a 48-word queue, or the 128th word with code 7, where an off-by-one in the ceiling arithmetic or in the wrap of the pointers shows up only after dozens of pushes. The stimulus walks a table of capacity and threshold codes with hand-computed expected counts. Each entry fills the queue word by word, records where the pulse appears, overruns by one, and drains while checking order. Directed sequences then drop the level below a threshold and refill it, to show that the pulse re-arms.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef struct packed {
    logic       on;
    logic       ie;
    logic [2:0] dcode;
    logic       mode;
    logic [2:0] tcode;
  } rxq_cfg_t;

  // Usable capacity selected by a depth code
  function automatic int unsigned cap_of(input logic [2:0] code);
    int unsigned c;
    case (code)
      3'd0:    c = 0;
      3'd1:    c = 4;
      3'd2:    c = 8;
      3'd3:    c = 16;
      3'd4:    c = 32;
      3'd5:    c = 48;
      3'd6:    c = 64;
      default: c = 128;
    endcase
    return c;
  endfunction

  // Fill count that corresponds to (n+1)/8 of the capacity, rounded up
  function automatic int unsigned thr_of(input int unsigned cap, input logic [2:0] n);
    return (cap * (int'(n) + 1) + 7) / 8;
  endfunction

endpackage

// File: rtl/rxq_ctrl_reg.sv
module rxq_ctrl_reg
  import rxq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output rxq_cfg_t    cfg,
  output logic [31:0] rdata,
  output logic        flush
);

  rxq_cfg_t cfg_q;
  rxq_cfg_t cfg_d;
  logic     unused_bits;

  assign unused_bits = ^{wdata[31:16], wdata[11], wdata[7:2], be[3:2]};

  always_comb begin
    cfg_d = cfg_q;
    if (wr) begin
      if (be[0]) begin
        cfg_d.on = wdata[0];
        cfg_d.ie = wdata[1];
      end
      if (be[1]) begin
        cfg_d.dcode = wdata[10:8];
        cfg_d.mode  = wdata[12];
        cfg_d.tcode = wdata[15:13];
      end
    end
  end

  // Empty the queue on a capacity change or when switched off
  assign flush = wr && ((cfg_d.dcode != cfg_q.dcode) || (cfg_q.on && !cfg_d.on));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg   = cfg_q;
  assign rdata = {16'h0000, cfg_q.tcode, cfg_q.mode, 1'b0, cfg_q.dcode, 6'b000000, cfg_q.ie, cfg_q.on};

  // R2: a write with no byte lane enabled leaves the readback unchanged
  a_r2_no_lane_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && be == 4'b0000) |=> $stable(rdata));

  // R2: the upper lanes never carry state
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> rdata[31:16] == 16'h0000);

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned MAX_DEPTH = 128,
  localparam int unsigned AW = $clog2(MAX_DEPTH),
  localparam int unsigned CW = $clog2(MAX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              on,
  input  logic [CW-1:0]     cap,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  output logic [DATA_W-1:0] pop_data,
  output logic              full,
  output logic              empty,
  output logic [CW-1:0]     level,
  output logic              overflow,
  output logic              push_acc,
  output logic              pop_acc
);

  logic [DATA_W-1:0] mem [MAX_DEPTH];
  logic [AW-1:0]     wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              ovf_q, ovf_d;
  logic              ovf_hit;

  assign full  = (cnt_q == cap);
  assign empty = (cnt_q == '0);

  assign push_acc = on && push_valid && !full && !flush;
  assign pop_acc  = pop_req && !empty && !flush;
  assign ovf_hit  = on && push_valid && full && !flush;

  // Pointers wrap at the configured capacity, not at a power of two
  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    ovf_d = ovf_q | ovf_hit;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
      ovf_d = 1'b0;
    end else begin
      if (push_acc) begin
        wr_d = (CW'(wr_q) + CW'(1) == cap) ? '0 : wr_q + AW'(1);
      end
      if (pop_acc) begin
        rd_d = (CW'(rd_q) + CW'(1) == cap) ? '0 : rd_q + AW'(1);
      end
      case ({push_acc, pop_acc})
        2'b10:   cnt_d = cnt_q + CW'(1);
        2'b01:   cnt_d = cnt_q - CW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  // Storage array, written only on an accepted push
  always_ff @(posedge clk) begin
    if (push_acc) begin
      mem[wr_q] <= push_data;
    end
  end

  assign pop_data = mem[rd_q];
  assign level    = cnt_q;
  assign overflow = ovf_q;

  // R3: the level never exceeds the configured capacity
  a_r3_level_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= cap);

  // R6: a push into a full queue does not change the level
  a_r6_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_valid && !pop_req && !flush) |=> cnt_q == $past(cnt_q));

  // R6: overflow only falls through a flush
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> (ovf_q || $past(flush)));

  // R7: popping an empty queue leaves it empty
  a_r7_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop_req && !push_valid) |=> cnt_q == '0);

endmodule

// File: rtl/rxq_irq.sv
module rxq_irq
  import rxq_pkg::*;
#(
  parameter int unsigned MAX_DEPTH = 128,
  localparam int unsigned CW = $clog2(MAX_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ie,
  input  logic          mode,
  input  logic [2:0]    tcode,
  input  logic [CW-1:0] cap,
  input  logic [CW-1:0] level,
  input  logic          push_acc,
  input  logic          pop_acc,
  output logic          irq
);

  logic [CW:0] thr;
  logic        thr_hit, msg_hit;
  logic        irq_q, irq_d;
  logic        thr_q, thr_d;

  assign thr = (CW+1)'(thr_of(int'(cap), tcode));

  // Crossing: a lone push lifts the level onto the threshold
  assign thr_hit = push_acc && !pop_acc && !mode && ({1'b0, level} + (CW+1)'(1) == thr);
  assign msg_hit = push_acc && mode;

  always_comb begin
    thr_d = ie && thr_hit;
    irq_d = ie && (thr_hit || msg_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      thr_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      thr_q <= thr_d;
    end
  end

  assign irq = irq_q;

  // R12: no request unless interrupts were enabled
  a_r12_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(ie));

  // R10: a threshold pulse lasts one cycle
  a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    thr_q |=> !thr_q);

  // R11: every stored word raises a request in per-message mode
  a_r11_each_msg: assert property (@(posedge clk) disable iff (!rst_n)
    (ie && mode && push_acc) |=> irq_q);

endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo
  import rxq_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned MAX_DEPTH = 128,
  localparam int unsigned CW = $clog2(MAX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  output logic [DATA_W-1:0] pop_data,
  output logic              full,
  output logic              empty,
  output logic [CW-1:0]     level,
  output logic              overflow,
  output logic              irq
);

  logic        rst_meta_q, rst_sync_q;
  rxq_cfg_t    cfg;
  logic        flush;
  logic [CW-1:0] cap;
  logic        push_acc, pop_acc;
  int unsigned cap_raw;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  rxq_ctrl_reg ctrl_i (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .wr    (cfg_wr),
    .be    (cfg_be),
    .wdata (cfg_wdata),
    .cfg   (cfg),
    .rdata (cfg_rdata),
    .flush (flush)
  );

  always_comb begin
    cap_raw = cap_of(cfg.dcode);
    if (cap_raw > MAX_DEPTH) begin
      cap_raw = MAX_DEPTH;
    end
  end
  assign cap = CW'(cap_raw);

  rxq_store #(
    .DATA_W    (DATA_W),
    .MAX_DEPTH (MAX_DEPTH)
  ) store_i (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .flush      (flush),
    .on         (cfg.on),
    .cap        (cap),
    .push_valid (push_valid),
    .push_data  (push_data),
    .pop_req    (pop_req),
    .pop_data   (pop_data),
    .full       (full),
    .empty      (empty),
    .level      (level),
    .overflow   (overflow),
    .push_acc   (push_acc),
    .pop_acc    (pop_acc)
  );

  rxq_irq #(
    .MAX_DEPTH (MAX_DEPTH)
  ) irq_i (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .ie       (cfg.ie),
    .mode     (cfg.mode),
    .tcode    (cfg.tcode),
    .cap      (cap),
    .level    (level),
    .push_acc (push_acc),
    .pop_acc  (pop_acc),
    .irq      (irq)
  );

  // R4: a switched-off queue holds nothing
  a_r4_off_empty: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !cfg.on |-> level == '0);

  // R9: capacity code 0 flags full and empty together
  a_r9_zero_cap: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (cfg.dcode == 3'd0) |-> (full && empty));

  // R8: a capacity change leaves the queue empty
  a_r8_flush_level: assert property (@(posedge clk) disable iff (!rst_sync_q)
    flush |=> (level == '0 && !overflow));

endmodule

// File: tb/rxq_fifo_tb_top.sv
module rxq_fifo_tb_top;

  localparam int DW = 32;
  localparam int CW = 8;

  logic          clk;
  logic          rst_n;
  logic          cfg_wr;
  logic [3:0]    cfg_be;
  logic [31:0]   cfg_wdata;
  logic [31:0]   cfg_rdata;
  logic          push_valid;
  logic [DW-1:0] push_data;
  logic          pop_req;
  logic [DW-1:0] pop_data;
  logic          full, empty, overflow, irq;
  logic [CW-1:0] level;

  int n_chk;
  int n_fail;
  int irq_cnt;
  bit done;

  rxq_fifo dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_be     (cfg_be),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .push_valid (push_valid),
    .push_data  (push_data),
    .pop_req    (pop_req),
    .pop_data   (pop_data),
    .full       (full),
    .empty      (empty),
    .level      (level),
    .overflow   (overflow),
    .irq        (irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Entries: {capacity code, threshold code, capacity, threshold count}
  localparam int NV = 12;
  localparam logic [21:0] VEC [NV] = '{
    {3'd1, 3'd0, 8'd4,   8'd1},
    {3'd1, 3'd5, 8'd4,   8'd3},
    {3'd2, 3'd2, 8'd8,   8'd3},
    {3'd3, 3'd1, 8'd16,  8'd4},
    {3'd4, 3'd6, 8'd32,  8'd28},
    {3'd5, 3'd0, 8'd48,  8'd6},
    {3'd5, 3'd2, 8'd48,  8'd18},
    {3'd5, 3'd6, 8'd48,  8'd42},
    {3'd5, 3'd7, 8'd48,  8'd48},
    {3'd6, 3'd3, 8'd64,  8'd32},
    {3'd7, 3'd0, 8'd128, 8'd16},
    {3'd7, 3'd7, 8'd128, 8'd128}
  };

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    if (irq) irq_cnt++;
  endtask

  task automatic wr_cfg(input logic [31:0] d, input logic [3:0] be);
    cfg_wr    = 1'b1;
    cfg_be    = be;
    cfg_wdata = d;
    tick();
    cfg_wr    = 1'b0;
    cfg_be    = 4'h0;
  endtask

  task automatic push(input logic [DW-1:0] d);
    push_valid = 1'b1;
    push_data  = d;
    tick();
    push_valid = 1'b0;
  endtask

  task automatic pop();
    pop_req = 1'b1;
    tick();
    pop_req = 1'b0;
  endtask

  function automatic logic [31:0] mk(input bit on, input bit ie, input logic [2:0] dc,
                                     input bit md, input logic [2:0] tc);
    return {16'h0, tc, md, 1'b0, dc, 6'b0, ie, on};
  endfunction

  initial begin
    done = 1'b0;
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; irq_cnt = 0;
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_be = 4'h0; cfg_wdata = '0;
    push_valid = 1'b0; push_data = '0; pop_req = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) tick();

    // R1 reset state
    chk("R1", "rdata", cfg_rdata, 0);
    chk("R1", "level", level, 0);
    chk("R1", "full/empty", {full, empty}, 2'b11);
    chk("R1", "ovf/irq", {overflow, irq}, 2'b00);

    // R2 byte lanes and reserved bits
    wr_cfg(32'hFFFF_FFFF, 4'b0011);
    chk("R2", "lanes 0-1 all ones", cfg_rdata, 32'h0000_F703);
    wr_cfg(32'h0000_0000, 4'b1100);
    chk("R2", "upper lanes only", cfg_rdata, 32'h0000_F703);
    wr_cfg(32'h0000_0000, 4'b0000);
    chk("R2", "no lanes", cfg_rdata, 32'h0000_F703);
    wr_cfg(32'h0000_0000, 4'b0001);
    chk("R2", "lane 0 only", cfg_rdata, 32'h0000_F700);

    // R9 capacity code 0
    wr_cfg(mk(1, 0, 3'd0, 0, 3'd0), 4'b0011);
    push(32'h1111);
    chk("R9", "level", level, 0);
    chk("R9", "full/empty", {full, empty}, 2'b11);
    chk("R9", "overflow", overflow, 1);

    // R4 disabled queue, then disable flush
    wr_cfg(mk(0, 1, 3'd3, 0, 3'd0), 4'b0011);
    push(32'h2222);
    chk("R4", "level off", level, 0);
    chk("R4", "ovf off", overflow, 0);
    wr_cfg(mk(1, 1, 3'd3, 0, 3'd7), 4'b0011);
    push(32'h3333); push(32'h4444);
    chk("R5", "level 2", level, 2);
    chk("R5", "head", pop_data, 32'h3333);
    wr_cfg(mk(0, 1, 3'd3, 0, 3'd7), 4'b0011);
    chk("R4", "flushed level", level, 0);
    chk("R4", "flushed empty", empty, 1);

    // R7 pop on empty
    wr_cfg(mk(1, 0, 3'd3, 0, 3'd7), 4'b0011);
    pop();
    chk("R7", "level", level, 0);
    chk("R7", "empty", empty, 1);
    push(32'hAAAA);
    chk("R7", "head after ignored pop", pop_data, 32'hAAAA);
    pop(); pop();
    chk("R7", "level after two pops", level, 0);

    // R8 capacity change flushes and clears overflow
    wr_cfg(mk(1, 0, 3'd1, 0, 3'd0), 4'b0011);
    for (int i = 0; i < 5; i++) push(32'h100 + i);
    chk("R6", "overflow set", overflow, 1);
    chk("R6", "level kept", level, 4);
    pop();
    chk("R6", "overflow sticky", overflow, 1);
    wr_cfg(mk(1, 0, 3'd2, 0, 3'd0), 4'b0011);
    chk("R8", "level", level, 0);
    chk("R8", "overflow", overflow, 0);
    push(32'hBEEF);
    chk("R8", "head restart", pop_data, 32'hBEEF);

    // R10 threshold table
    for (int e = 0; e < NV; e++) begin
      logic [2:0] dc, tc;
      int cap, thr, first, miss;
      dc = VEC[e][21:19]; tc = VEC[e][18:16];
      cap = int'(VEC[e][15:8]); thr = int'(VEC[e][7:0]);
      wr_cfg(32'h0, 4'b0011);
      wr_cfg(mk(1, 1, dc, 0, tc), 4'b0011);
      irq_cnt = 0; first = -1;
      for (int i = 0; i < cap; i++) begin
        push(32'(e * 1000 + i) ^ 32'h5A5A_0000);
        if (irq_cnt == 1 && first < 0) first = i + 1;
      end
      chk("R10", $sformatf("pulse count entry %0d", e), irq_cnt, 1);
      chk("R10", $sformatf("pulse position entry %0d", e), first, thr);
      chk("R3", $sformatf("full at cap entry %0d", e), {full, level}, {1'b1, 8'(cap)});
      push(32'hDEAD);
      chk("R6", $sformatf("overrun entry %0d", e), {overflow, level}, {1'b1, 8'(cap)});
      miss = 0;
      for (int i = 0; i < cap; i++) begin
        if (pop_data != (32'(e * 1000 + i) ^ 32'h5A5A_0000)) miss++;
        pop();
      end
      chk("R5", $sformatf("order entry %0d", e), miss, 0);
      chk("R5", $sformatf("drained entry %0d", e), {empty, level}, {1'b1, 8'd0});
    end

    // R10 re-arm: capacity 4, code 3 -> threshold 2
    wr_cfg(32'h0, 4'b0011);
    wr_cfg(mk(1, 1, 3'd1, 0, 3'd3), 4'b0011);
    irq_cnt = 0;
    push(32'h1); push(32'h2); push(32'h3);
    chk("R10", "single pulse above threshold", irq_cnt, 1);
    pop(); pop();
    push(32'h4);
    chk("R10", "re-arm after dropping", irq_cnt, 2);

    // R11 per-message mode
    wr_cfg(32'h0, 4'b0011);
    wr_cfg(mk(1, 1, 3'd2, 1, 3'd3), 4'b0011);
    irq_cnt = 0;
    push(32'h5); push(32'h6); push(32'h7);
    chk("R11", "pulse per word", irq_cnt, 3);

    // R12 interrupts disabled
    wr_cfg(32'h0, 4'b0011);
    wr_cfg(mk(1, 0, 3'd2, 1, 3'd0), 4'b0011);
    irq_cnt = 0;
    push(32'h8); push(32'h9);
    wr_cfg(32'h0, 4'b0011);
    wr_cfg(mk(1, 0, 3'd1, 0, 3'd0), 4'b0011);
    push(32'hA); push(32'hB);
    chk("R12", "no irq when disabled", irq_cnt, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule